// File: doc/BRIEF.md
# Guarded Watchdog Timer

The block is a watchdog counter that runs on its own slow clock. It forces a system reset when software fails to restart it before a chosen time-out. Software sees a single control byte through a write strobe and a readback bus. The byte holds a run bit, a 4-bit time-out code and an unlock indicator.

A static strap input picks one of two protection levels.

- **Relaxed level** (strap low): the timer starts stopped. Software may start it and change its time-out freely. Stopping it needs a two-step unlock.
- **Strict level** (strap high): the timer runs from reset and can never be stopped. Its time-out can only be changed through the same two-step unlock.

The unlock step is a write with both the unlock bit and the run bit set. The protected write must follow within four clock cycles. Software restarts the count with a one-cycle restart pulse. On expiry the block raises its reset output for one cycle and counts again from zero. All pins are plain control and status pins; there is no streaming data path, so no valid/ready handshake applies.

Top module: `wdt_guard`

## Requirements
- R1: The readback byte `ctrl_q` is laid out as follows: bits [3:0] hold the time-out code, bit 4 holds the run state, bit 5 is 1 while the unlock window is open, and bits [7:6] read 0. Writes use the same layout, with bit 5 acting as the unlock request.
- R2: After reset, the time-out code is 0, the window is closed and `sys_rst` is 0. The run bit is 0 at the relaxed level (`safe_lvl`=0) and 1 at the strict level (`safe_lvl`=1).
- R3: At the relaxed level, an ordinary write loads bits [3:0] into the time-out code, and a 1 in bit 4 starts the timer. An ordinary write with bit 4 at 0 leaves a running timer running.
- R4: A write with bits 5 and 4 both at 1 is the unlock write. It opens a window that accepts a protected write on any of the next four clock edges. While the window is open, readback bit 5 is 1.
- R5: At the relaxed level, a write with bit 5 at 0 made inside the window loads both the run bit and the time-out code, which lets the timer be stopped. It also closes the window.
- R6: At the strict level the run bit always reads 1. Ordinary writes change neither the run bit nor the time-out code. A write with bit 5 at 1 and bit 4 at 0 does not open the window.
- R7: At the strict level, a write with bit 5 at 0 made inside the window loads the time-out code and ignores bit 4.
- R8: A window that sees no protected write within its four edges closes by itself. A later write with bit 5 at 0 is then treated as an ordinary write.
- R9: With time-out code c, `sys_rst` rises 2^(BASE_EXP+min(c,9)) clock edges after the timer was started, restarted or had its configuration changed. Codes 10 to 15 behave like code 9.
- R10: A `kick` pulse restarts the count from zero. On expiry, `sys_rst` is high for exactly one cycle, and the next expiry follows one full time-out later.
- R11: While the timer is stopped, `sys_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| safe_lvl | input | 1 | Static protection level: 0 relaxed, 1 strict |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| kick | input | 1 | Restart pulse for the count |
| ctrl_q | output | 8 | Control byte readback |
| sys_rst | output | 1 | One-cycle system reset pulse on expiry |

## Verification
A wrong window counter or guard state shows up at once in readback bit 5. It also shows one cycle after a write, when a protected write is taken or refused. The tests probe both the fourth edge, which must accept, and the fifth edge, which must refuse. A faulty tap choice or restart condition appears only at the reset pin, as a `sys_rst` rise on the wrong edge. Every tap is therefore measured to the exact edge, within one time-out of the stimulus.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int P_RUN   = 4;
  localparam int P_UNL   = 5;

  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_tap_sel.sv
module wdt_tap_sel #(
  parameter int SEL_W    = 4,
  parameter int BASE_EXP = 11,
  parameter int MAX_CODE = 9,
  parameter int CNT_W    = BASE_EXP + MAX_CODE
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] limit
);
  localparam int N_CODES = 1 << SEL_W;

  logic [CNT_W-1:0] tab [N_CODES];

  // one terminal value per code; reserved codes fold onto the top tap
  for (genvar i = 0; i < N_CODES; i++) begin : g_tap
    localparam int EFF = (i > MAX_CODE) ? MAX_CODE : i;
    assign tab[i] = CNT_W'((64'd1 << (BASE_EXP + EFF)) - 64'd1);
  end

  assign limit = tab[sel];
endmodule

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              safe_lvl,
  input  logic              wr_en,
  input  logic [P_UNL:0]    wr_data,
  output wdt_cfg_t          cfg_o,
  output logic              win_open_o,
  output logic              chg_o
);
  localparam int WC_W = $clog2(WIN_CYC + 1);

  wdt_cfg_t         cfg_q, cfg_n;
  logic [WC_W-1:0]  win_q, win_n;
  logic             win_open, unlock_req, prot_wr;

  assign win_open   = (win_q != '0);
  assign unlock_req = wr_en & wr_data[P_UNL] & wr_data[P_RUN];
  assign prot_wr    = wr_en & ~wr_data[P_UNL] & win_open;

  always_comb begin
    cfg_n = cfg_q;
    if (safe_lvl) begin
      cfg_n.run = 1'b1;
      if (prot_wr) cfg_n.sel = wr_data[SEL_W-1:0];
    end else if (prot_wr) begin
      cfg_n.run = wr_data[P_RUN];
      cfg_n.sel = wr_data[SEL_W-1:0];
    end else if (wr_en) begin
      cfg_n.run = cfg_q.run | wr_data[P_RUN];
      cfg_n.sel = wr_data[SEL_W-1:0];
    end
  end

  always_comb begin
    if (unlock_req)     win_n = WC_W'(WIN_CYC);
    else if (prot_wr)   win_n = '0;
    else if (win_open)  win_n = win_q - 1'b1;
    else                win_n = win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.run <= safe_lvl;
      cfg_q.sel <= '0;
      win_q     <= '0;
    end else begin
      cfg_q <= cfg_n;
      win_q <= win_n;
    end
  end

  assign cfg_o      = cfg_q;
  assign win_open_o = win_open;
  assign chg_o      = (cfg_n != cfg_q);

  // R6: strict level never shows a stopped timer
  a_r6_strict_runs: assert property (@(posedge clk) disable iff (!rst_n)
    safe_lvl |-> cfg_q.run);

  // R5: relaxed level stops only through an open window
  a_r5_stop_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!safe_lvl && $past(cfg_q.run) && !cfg_q.run) |-> $past(win_open));

  // R7: strict level period moves only through an open window
  a_r7_period_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_lvl && (cfg_q.sel != $past(cfg_q.sel))) |-> $past(win_open));

  // R4: window opens only after an unlock write
  a_r4_open_by_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(wr_en && wr_data[P_UNL] && wr_data[P_RUN]));
endmodule

// File: rtl/wdt_tick_count.sv
module wdt_tick_count #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (!run || restart) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (cnt_q >= limit) begin
      cnt_q    <= '0;
      expire_o <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      expire_o <= 1'b0;
    end
  end

  // R10: reset pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  // R10: a restart suppresses expiry on the next edge
  a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expire_o);

  // R11: no pulse while stopped
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !expire_o);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_CODE = 9,
  parameter int WIN_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              safe_lvl,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              kick,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              sys_rst
);
  localparam int CNT_W = BASE_EXP + MAX_CODE;

  wdt_cfg_t         cfg;
  logic             win_open, cfg_chg;
  logic [CNT_W-1:0] limit;
  logic             unused_hi;

  assign unused_hi = ^wr_data[BYTE_W-1:P_UNL+1];

  wdt_cfg_lock #(.WIN_CYC(WIN_CYC)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .safe_lvl  (safe_lvl),
    .wr_en     (wr_en),
    .wr_data   (wr_data[P_UNL:0]),
    .cfg_o     (cfg),
    .win_open_o(win_open),
    .chg_o     (cfg_chg)
  );

  wdt_tap_sel #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .MAX_CODE(MAX_CODE), .CNT_W(CNT_W)
  ) u_tap (
    .sel  (cfg.sel),
    .limit(limit)
  );

  wdt_tick_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg.run),
    .restart (kick | cfg_chg),
    .limit   (limit),
    .expire_o(sys_rst)
  );

  assign ctrl_q = {{(BYTE_W-P_UNL-1){1'b0}}, win_open, cfg.run, cfg.sel};

  // R1: readback unlock flag agrees with a pending window after an unlock write
  a_r1_flag_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[P_UNL] && wr_data[P_RUN]) |=> ctrl_q[P_UNL]);
endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 3;
  localparam int NV = 8;
  localparam int TV_LVL  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam int TV_CODE [NV] = '{0, 2, 5, 9, 12, 15, 3, 10};
  localparam int TV_EXP  [NV] = '{8, 32, 256, 4096, 4096, 4096, 64, 4096};

  logic clk = 0, rst_n = 0, safe_lvl = 0, wr_en = 0, kick = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q;
  logic sys_rst;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard #(.BASE_EXP(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .safe_lvl(safe_lvl), .wr_en(wr_en),
    .wr_data(wr_data), .kick(kick), .ctrl_q(ctrl_q), .sys_rst(sys_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lvl);
    rst_n = 0; safe_lvl = lvl; wr_en = 0; kick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic meas(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_rst && n < 9000);
  endtask

  task automatic quiet(input int cyc, output int seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (sys_rst) seen++;
    end
  endtask

  initial begin
    int n, seen;
    @(negedge clk);
    // vector table: time-out per code and level (R9)
    for (int v = 0; v < NV; v++) begin
      do_reset(TV_LVL[v][0]);
      if (TV_LVL[v] == 0) wr(8'h10 | 8'(TV_CODE[v]));
      else begin
        wr(8'h30);
        wr(8'(TV_CODE[v]));
      end
      meas(n);
      check("R9 timeout", n, TV_EXP[v]);
    end

    // R2 reset state, both levels
    do_reset(0);
    check("R2 relaxed reset ctrl", ctrl_q, 8'h00);
    check("R2 reset sys_rst", sys_rst, 0);
    // R11 stopped timer stays quiet
    quiet(300, seen);
    check("R11 no pulse when stopped", seen, 0);
    // R3 free start and ordinary write keeps it running
    wr(8'h13);
    check("R3 start", ctrl_q, 8'h13);
    wr(8'h01);
    check("R3 ordinary write keeps run", ctrl_q, 8'h11);
    // R4 unlock opens window, R5 protected write on 4th edge stops timer (R8 edge)
    wr(8'h33);
    check("R4 window flag", ctrl_q, 8'h33);
    repeat (3) @(negedge clk);
    check("R4 window still open", ctrl_q[5], 1);
    wr(8'h01);
    check("R5 R8 stop on last window edge", ctrl_q, 8'h01);
    quiet(300, seen);
    check("R11 no pulse after stop", seen, 0);
    // R8 window lapses after four edges
    wr(8'h13);
    wr(8'h33);
    repeat (4) @(negedge clk);
    check("R8 window closed", ctrl_q, 8'h13);
    wr(8'h02);
    check("R8 late write is ordinary", ctrl_q, 8'h12);

    // R10 kicks hold off expiry, then pulse is one cycle and repeats
    do_reset(0);
    wr(8'h10);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (sys_rst) seen++;
      end
      kick = 1;
      @(negedge clk);
      kick = 0;
    end
    check("R10 kicks prevent reset", seen, 0);
    meas(n);
    check("R10 expiry after last kick", n, 8);
    @(negedge clk);
    check("R10 pulse one cycle", sys_rst, 0);
    meas(n);
    check("R10 next expiry", n, 7);

    // strict level
    do_reset(1);
    check("R2 strict reset ctrl", ctrl_q, 8'h10);
    wr(8'h07);
    check("R6 ordinary write ignored", ctrl_q, 8'h10);
    wr(8'h00);
    check("R6 cannot stop", ctrl_q, 8'h10);
    wr(8'h20);
    check("R6 unlock needs run bit", ctrl_q, 8'h10);
    wr(8'h30);
    check("R4 strict window flag", ctrl_q, 8'h30);
    wr(8'h02);
    check("R7 period loaded, run bit ignored", ctrl_q, 8'h12);
    meas(n);
    check("R9 strict new period", n, 32);
    wr(8'h30);
    repeat (4) @(negedge clk);
    wr(8'h05);
    check("R8 strict late write ignored", ctrl_q, 8'h12);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule